// File: doc/BRIEF.md
# SPI ADC conversion sequencer

This block is the master side of a 4-wire SPI link to an external 12-bit successive-approximation converter with four or eight analog inputs. A one-cycle start request, taken only while the block is idle, pulls chip select low. The block then sends a five-bit command (start bit, input mode, three select bits) and runs a serial clock derived from the system clock. It reads the 12-bit result back serially and returns it with a one-cycle valid strobe and a tag giving the mode and channel that produced it.

Each frame has a fixed length. The converter samples its input for one and a half serial clock periods, starting at the fourth rising edge after the start bit. The clock therefore runs at one steady rate for the whole frame. After the sampling window the converter sends one null bit and then the result. It changes its data line on falling edges, so the block samples on rising edges. Between frames, chip select stays high for a programmable minimum number of cycles, which ends any conversion and lets the converter enter standby.

The half period of the serial clock is `div_i + 1` system cycles. It is latched when a start request is taken. The parameter `NUM_CH` selects a 4-input or 8-input converter.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `cs_no` is 1 and `sclk_o`, `mosi_o`, `valid_o` and `busy_o` are 0.
- R2: A `start_i` pulse while `busy_o` is 0 drives `cs_no` low on the next clock edge. `busy_o` is 1 from that edge until the rest gap after the frame has run out, and it is 1 whenever `cs_no` is 0.
- R3: At serial rising edges 1 to 5 of a frame, `mosi_o` carries, in this order: a 1, the mode bit (1 = single-ended, 0 = pseudo-differential, the inverse of `diff_i`), then channel select bits 2, 1 and 0. `mosi_o` changes only while `sclk_o` is 0, and it is 0 after the fifth bit.
- R4: With `NUM_CH` = 4, select bit 2 is sent as 0 and `tag_chan_o[2]` is 0. With `NUM_CH` = 8, all three bits of `chan_i` are used.
- R5: `sclk_o` is 0 whenever `cs_no` is 1. Each frame has exactly 19 serial rising edges. Each clock level lasts `div_i + 1` system cycles, using the value latched at start. The first rising edge comes one half period after `cs_no` falls.
- R6: The 5th rising edge, which is the 4th after the start bit and opens the sampling window, comes 9 half periods after `cs_no` falls. All rising edges of a frame are equally spaced.
- R7: The bit read at rising edge 7 (the null bit) is discarded. The bits read at rising edges 8 to 19 form `code_o`, MSB first.
- R8: `valid_o` is high for exactly one cycle. It rises on the same edge as `cs_no` rises, `39 * (div_i + 1)` system cycles after the start was taken. At that time `code_o`, `tag_diff_o` and `tag_chan_o` hold the result and the request that produced it.
- R9: Between two frames, `cs_no` stays high for at least `GAP_CYC` system cycles.
- R10: `start_i` pulses, and changes to `diff_i`, `chan_i` and `div_i`, while `busy_o` is 1 start no frame and do not change the running frame or its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, one cycle, taken only while idle |
| diff_i | input | 1 | 1 = pseudo-differential pair, 0 = single-ended input |
| chan_i | input | 3 | Input number, or pair number and polarity |
| div_i | input | DIV_W | Serial half period minus one, in system cycles |
| busy_o | output | 1 | Frame or rest gap in progress |
| cs_no | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Result data from the converter |
| valid_o | output | 1 | One-cycle result strobe |
| code_o | output | 12 | Conversion result |
| tag_diff_o | output | 1 | Mode of the returned result |
| tag_chan_o | output | 3 | Select bits of the returned result |

## Verification
The bound checker checks these rules on every cycle: the serial clock is low while chip select is high, the data line changes only while the clock is low, the block is busy for as long as chip select is low, the strobe lasts one cycle and comes with the rise of chip select, the high gap is never shorter than the minimum, and a 4-input build never reports select bit 2. Other behaviour shows only in the bench scenarios, which use a behavioural converter model. These are the command bit order, the edge count, the even spacing of the edges and the time to the sampling edge, that the null bit is discarded (the model drives it as 1), the result and tag values, and that requests made while busy are ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W      = 12;
  localparam int CMD_W      = 5;
  // rises: command, window close, null, data
  localparam int RISE_TOTAL = CMD_W + 2 + RES_W;
  localparam int DATA_RISE0 = CMD_W + 3;
  localparam int HALF_LAST  = 2 * RISE_TOTAL;
  localparam int HALF_W     = $clog2(HALF_LAST + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_FRAME, ST_REST} st_e;

  typedef struct packed {
    logic       diff;
    logic [2:0] chan;
  } tag_t;
endpackage

// File: rtl/adc_seq_clkdiv.sv
module adc_seq_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
#(
  parameter int GAP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tick_i,
  output logic run_o,
  output logic busy_o,
  output logic load_o,
  output logic fall_o,
  output logic samp_o,
  output logic done_o,
  output logic cs_no,
  output logic sclk_o
);
  localparam int GAP_W = $clog2(GAP_CYC + 1);
  localparam logic [HALF_W-1:0] H_LAST  = HALF_W'(HALF_LAST);
  localparam logic [HALF_W-1:0] H_SAMP0 = HALF_W'(2 * DATA_RISE0 - 2);
  localparam logic [HALF_W-1:0] H_SAMP1 = HALF_W'(HALF_LAST - 2);
  localparam logic [GAP_W-1:0]  G_END   = GAP_W'(GAP_CYC - 1);

  st_e               st_q;
  logic [HALF_W-1:0] half_q;
  logic [GAP_W-1:0]  rest_q;
  logic              cs_q;
  logic              sclk_q;

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign run_o  = (st_q == ST_FRAME);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = tick_i && (half_q == H_LAST);
  // odd half: clock high, its end is a falling edge
  assign fall_o = tick_i && half_q[0];
  // even half ending: rising edge; only data rises are captured
  assign samp_o = tick_i && !half_q[0] && (half_q >= H_SAMP0) && (half_q <= H_SAMP1);
  assign cs_no  = cs_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      half_q <= '0;
      rest_q <= '0;
      cs_q   <= 1'b1;
      sclk_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_FRAME;
            half_q <= '0;
            cs_q   <= 1'b0;
          end
        end
        ST_FRAME: begin
          if (tick_i) begin
            if (done_o) begin
              st_q   <= ST_REST;
              rest_q <= '0;
              half_q <= '0;
              cs_q   <= 1'b1;
            end else begin
              half_q <= half_q + 1'b1;
              sclk_q <= ~sclk_q;
            end
          end
        end
        ST_REST: begin
          if (rest_q == G_END) st_q <= ST_IDLE;
          else                 rest_q <= rest_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_shreg.sv
module adc_seq_shreg
  import adc_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             fall_i,
  input  logic             samp_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic [RES_W-1:0] res_o
);
  logic [CMD_W-1:0] cmd_q;
  logic [RES_W-1:0] res_q;

  assign mosi_o = cmd_q[CMD_W-1];
  assign res_o  = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (load_i) cmd_q <= cmd_i;
    else if (fall_i) cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     res_q <= '0;
    else if (load_i) res_q <= '0;
    else if (samp_i) res_q <= {res_q[RES_W-2:0], miso_i};
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int DIV_W   = 8,
  parameter int GAP_CYC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             diff_i,
  input  logic [2:0]       chan_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic             valid_o,
  output logic [RES_W-1:0] code_o,
  output logic             tag_diff_o,
  output logic [2:0]       tag_chan_o
);
  logic [DIV_W-1:0] div_q;
  logic [2:0]       chan_eff;
  logic [CMD_W-1:0] cmd;
  tag_t             tag_q, tag_out_q;
  logic             load, run, tick, fall, samp, done;
  logic [RES_W-1:0] res, code_q;
  logic             valid_q;

  generate
    if (NUM_CH == 8) begin : g_sel8
      assign chan_eff = chan_i;
    end else begin : g_sel4
      assign chan_eff = {1'b0, chan_i[1:0]};
    end
  endgenerate

  // start, mode (1 = single-ended), select msb..lsb
  assign cmd = {1'b1, ~diff_i, chan_eff};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q     <= '0;
      tag_q     <= '0;
      tag_out_q <= '0;
      code_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= done;
      if (load) begin
        div_q <= div_i;
        tag_q <= '{diff: diff_i, chan: chan_eff};
      end
      if (done) begin
        code_q    <= res;
        tag_out_q <= tag_q;
      end
    end
  end

  adc_seq_clkdiv #(.DIV_W(DIV_W)) u_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_q),
    .tick_o(tick)
  );

  adc_seq_fsm #(.GAP_CYC(GAP_CYC)) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .tick_i (tick),
    .run_o  (run),
    .busy_o (busy_o),
    .load_o (load),
    .fall_o (fall),
    .samp_o (samp),
    .done_o (done),
    .cs_no  (cs_no),
    .sclk_o (sclk_o)
  );

  adc_seq_shreg u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cmd_i (cmd),
    .fall_i(fall),
    .samp_i(samp),
    .miso_i(miso_i),
    .mosi_o(mosi_o),
    .res_o (res)
  );

  assign valid_o    = valid_q;
  assign code_o     = code_q;
  assign tag_diff_o = tag_out_q.diff;
  assign tag_chan_o = tag_out_q.chan;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int NUM_CH  = 8,
  parameter int GAP_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_no,
  input logic sclk_o,
  input logic mosi_o,
  input logic busy_o,
  input logic valid_o,
  input logic tag_top_i
);
  int hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               hi_cnt <= GAP_CYC;
    else if (!cs_no)           hi_cnt <= 0;
    else if (hi_cnt < GAP_CYC) hi_cnt <= hi_cnt + 1;
  end

  p_sclk_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_mosi_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mosi_o) |-> !sclk_o);

  p_busy_frame_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  p_valid_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));

  p_cs_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= GAP_CYC));

  p_sel_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && NUM_CH == 4) |-> !tag_top_i);
endmodule

bind adc_seq_ctrl adc_seq_chk #(.NUM_CH(NUM_CH), .GAP_CYC(GAP_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_no    (cs_no),
  .sclk_o   (sclk_o),
  .mosi_o   (mosi_o),
  .busy_o   (busy_o),
  .valid_o  (valid_o),
  .tag_top_i(tag_chan_o[2])
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_resp_model (
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  input  logic [11:0] code_i,
  output logic        miso,
  output logic [4:0]  cmd_o,
  output int          rises_o,
  output int          frames_o,
  output bit          even_o,
  output longint      gap_o,
  output longint      t5_o
);
  int          rises = 0;
  int          frames = 0;
  logic [4:0]  cmd = '0;
  logic [11:0] snap = '0;
  logic        miso_r = 1'b0;
  bit          even = 1'b1;
  longint      t_last = 0, p0 = 0, per = 0, t_hi = 0, t_lo = 0, gap = 0, t5 = 0;

  always @(negedge cs_n or posedge sclk) begin
    if (sclk && !cs_n) begin
      rises = rises + 1;
      if (rises <= 5) cmd = {cmd[3:0], mosi};
      if (rises >= 2) begin
        per = $time - t_last;
        if (rises == 2) p0 = per;
        else if (per != p0) even = 1'b0;
      end
      t_last = $time;
      if (rises == 5) begin
        snap = code_i;
        t5   = $time - t_lo;
      end
    end else if (!cs_n) begin
      rises = 0;
      cmd   = '0;
      even  = 1'b1;
      t_lo  = $time;
      gap   = $time - t_hi;
    end
  end

  // null bit deliberately driven as 1
  always @(negedge sclk) begin
    if (!cs_n) begin
      if (rises == 6)                    miso_r = 1'b1;
      else if (rises >= 7 && rises <= 18) miso_r = snap[18 - rises];
      else                               miso_r = 1'b0;
    end
  end

  always @(posedge cs_n) begin
    t_hi   = $time;
    frames = frames + 1;
  end

  assign miso     = miso_r;
  assign cmd_o    = cmd;
  assign rises_o  = rises;
  assign frames_o = frames;
  assign even_o   = even;
  assign gap_o    = gap;
  assign t5_o     = t5;
endmodule

module adc_seq_ctrl_bench;
  localparam int GAP    = 4;
  localparam int DIV_W  = 8;
  localparam int CLK_NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_v = 1'b0, diff_v = 1'b0;
  logic [2:0]  chan_v = '0;
  logic [DIV_W-1:0] div_v = '0;
  logic [11:0] code_v = '0;

  logic busy_o, cs_no, sclk_o, mosi_o, miso, valid_o, tag_diff_o;
  logic [11:0] code_o;
  logic [2:0]  tag_chan_o;
  logic busy4, cs4, sclk4, mosi4, miso4, valid4, tdiff4;
  logic [11:0] code4;
  logic [2:0]  tchan4;

  logic [4:0] cmd_m, cmd_m4;
  int         rises_m, rises_m4, frames_m, frames_m4;
  bit         even_m, even_m4;
  longint     gap_m, gap_m4, t5_m, t5_m4;

  int errs = 0;
  int checks = 0;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.NUM_CH(8), .DIV_W(DIV_W), .GAP_CYC(GAP)) u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v), .diff_i(diff_v), .chan_i(chan_v),
    .div_i(div_v), .busy_o(busy_o), .cs_no(cs_no), .sclk_o(sclk_o), .mosi_o(mosi_o),
    .miso_i(miso), .valid_o(valid_o), .code_o(code_o), .tag_diff_o(tag_diff_o),
    .tag_chan_o(tag_chan_o));

  adc_seq_ctrl #(.NUM_CH(4), .DIV_W(DIV_W), .GAP_CYC(GAP)) u_adc_seq_ctrl_c4 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_v), .diff_i(diff_v), .chan_i(chan_v),
    .div_i(div_v), .busy_o(busy4), .cs_no(cs4), .sclk_o(sclk4), .mosi_o(mosi4),
    .miso_i(miso4), .valid_o(valid4), .code_o(code4), .tag_diff_o(tdiff4),
    .tag_chan_o(tchan4));

  adc_resp_model u_resp (
    .sclk(sclk_o), .cs_n(cs_no), .mosi(mosi_o), .code_i(code_v), .miso(miso),
    .cmd_o(cmd_m), .rises_o(rises_m), .frames_o(frames_m), .even_o(even_m),
    .gap_o(gap_m), .t5_o(t5_m));

  adc_resp_model u_resp_c4 (
    .sclk(sclk4), .cs_n(cs4), .mosi(mosi4), .code_i(code_v), .miso(miso4),
    .cmd_o(cmd_m4), .rises_o(rises_m4), .frames_o(frames_m4), .even_o(even_m4),
    .gap_o(gap_m4), .t5_o(t5_m4));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_cmd(input bit d, input logic [2:0] ch, input bit four);
    logic [2:0] c;
    c = four ? {1'b0, ch[1:0]} : ch;
    return {1'b1, ~d, c};
  endfunction

  task automatic run_conv(input bit d, input logic [2:0] ch, input logic [11:0] c,
                          input int dv, input bit poke);
    int cnt, fr0, fr4;
    cnt = 0;
    while (busy_o && cnt < 1000) begin @(negedge clk); cnt++; end
    code_v = c; diff_v = d; chan_v = ch; div_v = DIV_W'(dv);
    fr0 = frames_m; fr4 = frames_m4;
    start_v = 1'b1;
    @(negedge clk);
    start_v = 1'b0;
    chk(busy_o && !cs_no, "R2 busy and cs low after start", {busy_o, cs_no}, 2);
    cnt = 0;
    while (!valid_o && cnt < 5000) begin
      @(negedge clk);
      cnt++;
      if (poke && cnt == 10) begin
        start_v = 1'b1; chan_v = ~ch; diff_v = ~d; div_v = DIV_W'(dv + 2);
      end else if (poke && cnt == 11) begin
        start_v = 1'b0;
      end
    end
    chk(cnt == 39 * (dv + 1), "R8 latency to valid", cnt, 39 * (dv + 1));
    chk(code_o == c, "R7 result code", code_o, c);
    chk(tag_diff_o == d && tag_chan_o == ch, "R8 tag", {tag_diff_o, tag_chan_o}, {d, ch});
    chk(cs_no, "R8 cs high with valid", cs_no, 1);
    chk(valid4 && code4 == c, "R4 four-input result", code4, c);
    chk(tchan4 == {1'b0, ch[1:0]}, "R4 four-input tag", tchan4, {1'b0, ch[1:0]});
    chk(cmd_m == exp_cmd(d, ch, 1'b0), "R3 command bits", cmd_m, exp_cmd(d, ch, 1'b0));
    chk(cmd_m4 == exp_cmd(d, ch, 1'b1), "R4 command bits", cmd_m4, exp_cmd(d, ch, 1'b1));
    chk(rises_m == 19, "R5 rising edge count", rises_m, 19);
    chk(even_m, "R6 even edge spacing", even_m, 1);
    chk(t5_m == 9 * (dv + 1) * CLK_NS, "R6 sampling edge time", t5_m, 9 * (dv + 1) * CLK_NS);
    chk(gap_m >= GAP * CLK_NS, "R9 cs high gap", gap_m, GAP * CLK_NS);
    chk(frames_m - fr0 == 1 && frames_m4 - fr4 == 1, "R10 one frame per request",
        frames_m - fr0, 1);
    @(negedge clk);
    chk(!valid_o, "R8 valid one cycle", valid_o, 0);
    chk(busy_o && !sclk_o, "R2 busy during rest gap", busy_o, 1);
  endtask

  initial begin
    #(1_000_000);
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(cs_no && !sclk_o && !mosi_o && !valid_o && !busy_o, "R1 reset state",
        {cs_no, sclk_o, mosi_o, valid_o, busy_o}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_no && !busy_o, "R1 idle after reset", {cs_no, busy_o}, 2);
    // directed corners
    run_conv(1'b0, 3'd0, 12'h000, 0, 1'b0);
    run_conv(1'b0, 3'd7, 12'hFFF, 1, 1'b0);
    run_conv(1'b1, 3'd3, 12'hA5A, 3, 1'b1);
    run_conv(1'b1, 3'd6, 12'h800, 0, 1'b0);
    run_conv(1'b0, 3'd5, 12'h001, 2, 1'b1);
    for (int i = 0; i < 24; i++) begin
      run_conv(1'($urandom % 2), 3'($urandom % 8), 12'($urandom % 4096),
               int'($urandom % 4), (i % 8) == 5);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule